// File: doc/BRIEF.md
# Debug Serial Command Port

This block lets an external debug controller talk to a halted processor core over a slow synchronous serial link. The controller owns the serial clock. It sends an 8-bit command and then moves a 24-bit data word in or out. Every hand-off is signalled back to the controller as a short low pulse on the serial output line, so the controller never needs a separate ready wire.

The serial clock, serial input and request line are synchronised into the core clock domain and oversampled there. The serial clock must run at no more than one eighth of the core clock. Bits are captured on falling serial-clock edges, most significant bit first. Read data is launched on rising serial-clock edges. The request line has two jobs. Outside debug mode it asks the core to halt. Inside debug mode it restarts the serial controller after the controller and the port lose step.

Top module: `dbg_serial_port`

## Requirements
- R1: While reset is high and on the cycle after, `dbg_sdo` is high, `halt_req` is low, and `cmd_valid` and `wr_valid` are low.
- R2: A rising edge on `dbg_req` while `core_halted` is low sets `halt_req`. `halt_req` stays high until `core_halted` is high, and then drops on the next clock.
- R3: Each acknowledge is a low pulse on `dbg_sdo` lasting exactly 4 core clocks. When `core_halted` rises, exactly one such pulse is sent. Outside acknowledges and read transfers, `dbg_sdo` idles high.
- R4: While `core_halted` is low, serial clock and data activity causes no `cmd_valid`, no `wr_valid` and no low level on `dbg_sdo`.
- R5: In debug mode, 8 bits are captured on falling `dbg_sck` edges, most significant bit first. The result appears on `cmd_out` with a one-cycle `cmd_valid` pulse.
- R6: A command with bit 7 set is a read. It is followed by one acknowledge. After that, each of the next 24 rising `dbg_sck` edges places the next bit of `rd_data` on `dbg_sdo`, most significant bit first. After the 24th falling edge, `dbg_sdo` returns high.
- R7: A command with bit 7 clear is a write. It is followed by one acknowledge. The port then captures 24 bits, most significant bit first, on falling edges and presents them on `wr_data` with a one-cycle `wr_valid` pulse. A second acknowledge follows.
- R8: In debug mode, a rising edge on `dbg_req` produces one acknowledge and discards any partly received command. Serial input is ignored until `dbg_req` falls, and then a fresh command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sck | input | 1 | Serial clock from the debug controller |
| dbg_sdi | input | 1 | Serial data in |
| dbg_req | input | 1 | Halt request; controller restart while in debug mode |
| dbg_sdo | output | 1 | Serial data out and acknowledge pulses |
| halt_req | output | 1 | Request to the core to halt |
| core_halted | input | 1 | Core is halted (debug mode) |
| rd_data | input | 24 | Core word returned by read commands |
| cmd_out | output | 8 | Last received command |
| cmd_valid | output | 1 | One-cycle pulse when a command is complete |
| wr_data | output | 24 | Last received write word |
| wr_valid | output | 1 | One-cycle pulse when a write word is complete |

## Verification
A bit counter that is off by one, or a shift in the wrong direction, shows up as a wrong `cmd_out` or `wr_data` value. It also moves the acknowledge by a whole serial bit time, so the bench sees it within one transfer. A port that misses the halted state, or fails to leave it, shows up as a `cmd_valid` or a low `dbg_sdo` while the core runs. A stuck restart state shows up at once, because the command that follows the restart never completes. Read-path faults show up as wrong or shifted bits on `dbg_sdo`, and an acknowledge of the wrong length shows up as a low-pulse count other than 4.

// File: rtl/dbg_serial_pkg.sv
package dbg_serial_pkg;
    parameter int CMD_W   = 8;
    parameter int DATA_W  = 24;
    parameter int ACK_LEN = 4;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_OFF,     // core running, serial input ignored
        ST_CMD,     // collecting command bits
        ST_SEND,    // shifting read data out
        ST_RECV,    // collecting write data
        ST_RHOLD    // controller restart, waiting for request release
    } port_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
    } edge_t;

    function automatic logic is_read(input logic [CMD_W-1:0] cmd);
        return cmd[CMD_W-1];
    endfunction
endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync
    import dbg_serial_pkg::*;
#(
    parameter int W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [W-1:0]          din,
    output edge_t [W-1:0]         ev
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [2:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= {q[1:0], din[g]};
        end
        assign ev[g].level = q[1];
        assign ev[g].rise  = q[1] & ~q[2];
        assign ev[g].fall  = ~q[1] & q[2];
    end
endmodule

// File: rtl/dbgp_ack_gen.sv
module dbgp_ack_gen #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (go)          cnt <= CW'(LEN);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign active = (cnt != '0);
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dbg_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_sck,
    input  logic              dbg_sdi,
    input  logic              dbg_req,
    output logic              dbg_sdo,
    output logic              halt_req,
    input  logic              core_halted,
    input  logic [DATA_W-1:0] rd_data,
    output logic [CMD_W-1:0]  cmd_out,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_valid
);
    localparam int I_SCK = 0;
    localparam int I_SDI = 1;
    localparam int I_REQ = 2;

    edge_t [2:0]       ev;
    port_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              tx_bit;
    logic              ack_go;
    logic              ack_active;
    logic              enter_dbg, cmd_done, wr_done, ctl_rst;

    dbgp_sync #(.W(3)) sync_i (
        .clk (clk),
        .rst (rst),
        .din ({dbg_req, dbg_sdi, dbg_sck}),
        .ev  (ev)
    );

    dbgp_ack_gen #(.LEN(ACK_LEN)) ack_i (
        .clk    (clk),
        .rst    (rst),
        .go     (ack_go),
        .active (ack_active)
    );

    always_comb begin
        enter_dbg = core_halted && (state == ST_OFF);
        ctl_rst   = core_halted && (state != ST_OFF) && ev[I_REQ].rise;
        cmd_done  = core_halted && !ctl_rst && (state == ST_CMD) &&
                    ev[I_SCK].fall && (cnt == CNT_W'(CMD_W - 1));
        wr_done   = core_halted && !ctl_rst && (state == ST_RECV) &&
                    ev[I_SCK].fall && (cnt == CNT_W'(DATA_W - 1));
        ack_go    = enter_dbg | ctl_rst | cmd_done | wr_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OFF;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            tx_bit    <= 1'b1;
            cmd_out   <= '0;
            cmd_valid <= 1'b0;
            wr_data   <= '0;
            wr_valid  <= 1'b0;
            halt_req  <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;

            if (core_halted)          halt_req <= 1'b0;
            else if (ev[I_REQ].rise)  halt_req <= 1'b1;

            if (!core_halted) begin
                state  <= ST_OFF;
                cnt    <= '0;
                tx_bit <= 1'b1;
            end else if (ctl_rst) begin
                state  <= ST_RHOLD;
                cnt    <= '0;
                tx_bit <= 1'b1;
            end else begin
                unique case (state)
                    ST_OFF: begin
                        state <= ST_CMD;
                        cnt   <= '0;
                    end
                    ST_RHOLD: begin
                        if (ev[I_REQ].fall) begin
                            state <= ST_CMD;
                            cnt   <= '0;
                        end
                    end
                    ST_CMD: begin
                        if (ev[I_SCK].fall) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], ev[I_SDI].level};
                            cnt   <= cnt + 1'b1;
                            if (cmd_done) begin
                                cmd_out   <= {rx_sh[CMD_W-2:0], ev[I_SDI].level};
                                cmd_valid <= 1'b1;
                                cnt       <= '0;
                                if (is_read({rx_sh[CMD_W-2:0], ev[I_SDI].level})) begin
                                    tx_sh <= rd_data;
                                    state <= ST_SEND;
                                end else begin
                                    state <= ST_RECV;
                                end
                            end
                        end
                    end
                    ST_SEND: begin
                        if (ev[I_SCK].rise && cnt < CNT_W'(DATA_W)) begin
                            tx_bit <= tx_sh[DATA_W-1];
                            tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end else if (ev[I_SCK].fall && cnt == CNT_W'(DATA_W)) begin
                            state  <= ST_CMD;
                            cnt    <= '0;
                            tx_bit <= 1'b1;
                        end
                    end
                    ST_RECV: begin
                        if (ev[I_SCK].fall) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], ev[I_SDI].level};
                            cnt   <= cnt + 1'b1;
                            if (wr_done) begin
                                wr_data  <= {rx_sh[DATA_W-2:0], ev[I_SDI].level};
                                wr_valid <= 1'b1;
                                cnt      <= '0;
                                state    <= ST_CMD;
                            end
                        end
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    assign dbg_sdo = ack_active ? 1'b0 : tx_bit;
endmodule

// File: rtl/dbg_serial_port_chk.sv
module dbg_serial_port_chk
    import dbg_serial_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic dbg_sdo,
    input logic halt_req,
    input logic core_halted,
    input logic cmd_valid,
    input logic wr_valid,
    input logic ack_active
);
    logic [3:0] ack_run;
    always_ff @(posedge clk) begin
        if (rst || !ack_active) ack_run <= '0;
        else if (ack_run != 4'hF) ack_run <= ack_run + 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (dbg_sdo && !halt_req && !cmd_valid && !wr_valid));

    // R2
    halt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_req && core_halted) |=> !halt_req);

    // R3
    ack_len_chk: assert property (@(posedge clk) disable iff (rst)
        ack_run <= 4'(ACK_LEN));

    // R3
    ack_low_chk: assert property (@(posedge clk) disable iff (rst)
        ack_active |-> !dbg_sdo);

    // R4
    run_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_halted && !$past(core_halted)) |-> (!cmd_valid && !wr_valid));

    // R5
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);
endmodule

bind dbg_serial_port dbg_serial_port_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .dbg_sdo     (dbg_sdo),
    .halt_req    (halt_req),
    .core_halted (core_halted),
    .cmd_valid   (cmd_valid),
    .wr_valid    (wr_valid),
    .ack_active  (ack_active)
);

// File: tb/dbg_serial_port_tb_top.sv
module dbg_serial_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_sck = 1'b0;
    logic        dbg_sdi = 1'b0;
    logic        dbg_req = 1'b0;
    logic        core_halted = 1'b0;
    logic [23:0] rd_data = '0;
    logic        dbg_sdo, halt_req, cmd_valid, wr_valid;
    logic [7:0]  cmd_out;
    logic [23:0] wr_data;

    int checks = 0;
    int failures = 0;
    int cmd_cnt = 0;
    int wr_cnt = 0;
    int low_cnt = 0;
    logic [7:0]  last_cmd = '0;
    logic [23:0] last_wr = '0;

    always #2 clk = ~clk;

    dbg_serial_port dut_i (
        .clk(clk), .rst(rst), .dbg_sck(dbg_sck), .dbg_sdi(dbg_sdi),
        .dbg_req(dbg_req), .dbg_sdo(dbg_sdo), .halt_req(halt_req),
        .core_halted(core_halted), .rd_data(rd_data), .cmd_out(cmd_out),
        .cmd_valid(cmd_valid), .wr_data(wr_data), .wr_valid(wr_valid)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin cmd_cnt++; last_cmd = cmd_out; end
            if (wr_valid)  begin wr_cnt++;  last_wr  = wr_data; end
            if (!dbg_sdo)  low_cnt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        dbg_sdi = b;
        tick(7);
        dbg_sck = 1'b1;
        tick(8);
        dbg_sck = 1'b0;
        tick(1);
    endtask

    task automatic send_word(input logic [23:0] w, input int n);
        for (int k = n - 1; k >= 0; k--) send_bit(w[k]);
    endtask

    task automatic get_bit(output logic b);
        tick(7);
        dbg_sck = 1'b1;
        tick(7);
        b = dbg_sdo;
        tick(1);
        dbg_sck = 1'b0;
        tick(1);
    endtask

    task automatic expect_ack(input string req);
        int wait_n = 0;
        int len = 0;
        while (dbg_sdo && wait_n < 60) begin tick(1); wait_n++; end
        while (!dbg_sdo && len < 40) begin tick(1); len++; end
        check(len == 4, req, len, 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] got;
        logic        b;
        int          c0, w0;
        tick(5);
        // R1 reset state
        check(dbg_sdo == 1'b1, "R1 sdo", dbg_sdo, 1);
        check(halt_req == 1'b0, "R1 halt_req", halt_req, 0);
        check(cmd_valid == 1'b0 && wr_valid == 1'b0, "R1 valids",
              {cmd_valid, wr_valid}, 0);
        rst = 1'b0;
        tick(3);

        // R4 serial traffic while running is ignored
        low_cnt = 0; c0 = cmd_cnt; w0 = wr_cnt;
        send_word(24'h0000A5, 8);
        send_word(24'h5A3C96, 24);
        tick(10);
        check(cmd_cnt == c0 && wr_cnt == w0, "R4 no strobes", cmd_cnt - c0, 0);
        check(low_cnt == 0, "R4 sdo idle", low_cnt, 0);

        // R2 halt request
        dbg_req = 1'b1;
        tick(6);
        check(halt_req == 1'b1, "R2 set", halt_req, 1);
        core_halted = 1'b1;
        // R3 entry acknowledge
        expect_ack("R3 entry ack");
        check(halt_req == 1'b0, "R2 clear", halt_req, 0);
        dbg_req = 1'b0;
        tick(10);

        // R5 R6 read sweep
        for (int i = 0; i < 6; i++) begin
            logic [23:0] d;
            logic [7:0]  cmd;
            d = 24'((i * 24'h2D4F1B) ^ 24'hC3A5E7);
            cmd = 8'h80 | 8'(i * 5);
            rd_data = d;
            c0 = cmd_cnt;
            send_word({16'h0, cmd}, 8);
            expect_ack("R6 read ack");
            check(cmd_cnt == c0 + 1 && last_cmd == cmd, "R5 read cmd", last_cmd, cmd);
            for (int k = 23; k >= 0; k--) begin
                get_bit(b);
                got[k] = b;
            end
            check(got == d, "R6 read data", got, d);
            tick(6);
            check(dbg_sdo == 1'b1, "R6 sdo idle after", dbg_sdo, 1);
        end

        // R5 R7 write sweep
        for (int i = 0; i < 6; i++) begin
            logic [23:0] d;
            logic [7:0]  cmd;
            d = ~24'(i * 24'h13579B);
            cmd = 8'(i * 8'h13) & 8'h7F;
            c0 = cmd_cnt; w0 = wr_cnt;
            send_word({16'h0, cmd}, 8);
            expect_ack("R7 request ack");
            check(cmd_cnt == c0 + 1 && last_cmd == cmd, "R5 write cmd", last_cmd, cmd);
            send_word(d, 24);
            expect_ack("R7 done ack");
            check(wr_cnt == w0 + 1 && last_wr == d, "R7 write data", last_wr, d);
        end

        // R8 controller restart discards partial command
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        tick(4);
        dbg_req = 1'b1;
        expect_ack("R8 restart ack");
        c0 = cmd_cnt;
        send_bit(1'b1); send_bit(1'b0);
        tick(6);
        check(cmd_cnt == c0, "R8 input ignored in hold", cmd_cnt - c0, 0);
        dbg_req = 1'b0;
        tick(6);
        w0 = wr_cnt;
        send_word(24'h000005, 8);
        expect_ack("R8 fresh cmd ack");
        check(cmd_cnt == c0 + 1 && last_cmd == 8'h05, "R8 fresh cmd", last_cmd, 8'h05);
        send_word(24'h8E1F00, 24);
        expect_ack("R8 done ack");
        check(wr_cnt == w0 + 1 && last_wr == 24'h8E1F00, "R8 write", last_wr, 24'h8E1F00);

        // R4 again after leaving debug mode
        core_halted = 1'b0;
        tick(4);
        low_cnt = 0; c0 = cmd_cnt;
        send_word(24'h0000C3, 8);
        tick(10);
        check(cmd_cnt == c0, "R4 after exit", cmd_cnt - c0, 0);
        check(low_cnt == 0, "R4 sdo after exit", low_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule